// File: doc/BRIEF.md
# Privilege-Checked Segment Address Decoder

This block takes a 32-bit virtual address together with the current privilege mode, the kind of access and an error-level flag. It sorts the address into one of five fixed windows and returns exactly one verdict. The verdict is direct (unmapped, with the physical address computed here), translate (the address must be looked up in the TLB), or address error (the access is not allowed in the current mode). An address error also carries a bit saying whether it counts as a store fault or as a load fault.

Requests arrive on a valid/ready channel and leave on another. One register stage sits between them. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. Its verdict appears with `out_valid` after that edge and stays unchanged until a rising edge where `out_ready` is high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-pressure from `out_ready` reaches the input with no extra delay and no request is ever dropped or duplicated.

Top module: `addr_seg_decoder`

## Requirements
- R1: An address with bit 31 clear (0x00000000 to 0x7FFFFFFF) gives the translate verdict in every privilege mode while the error-level flag is low.
- R2: While the error-level flag is high, an address with bit 31 clear gives the direct verdict, and its physical address equals the virtual address unchanged.
- R3: An address from 0x80000000 to 0x9FFFFFFF gives the direct verdict in kernel mode, with physical address = address − 0x80000000. In any other mode it gives an address error.
- R4: An address from 0xA0000000 to 0xBFFFFFFF gives the direct verdict in kernel mode, with physical address = address − 0xA0000000. In any other mode it gives an address error.
- R5: An address from 0xC0000000 to 0xDFFFFFFF gives the translate verdict in supervisor or kernel mode and an address error in user mode.
- R6: An address from 0xE0000000 to 0xFFFFFFFF gives the translate verdict in kernel mode only and an address error otherwise.
- R7: Access encoding on `in_access` is 00 load, 01 store, 10 instruction fetch, 11 treated as a load. On an address error, `out_err_store` is 1 for a store and 0 for all other access codes. When there is no address error, `out_err_store` is 0.
- R8: While `out_valid` is high, exactly one of `out_unmapped`, `out_to_tlb`, `out_addr_err` is 1, and `out_phys` is zero unless `out_unmapped` is 1.
- R9: Mode encoding on `in_mode` is 00 user, 01 supervisor, 10 kernel, and 11 also kernel. The error-level flag has no effect on addresses with bit 31 set.
- R10: `in_ready` equals `!out_valid || out_ready`. A request accepted at one edge is presented with `out_valid` high after that edge. Outputs hold steady while `out_valid` is high and `out_ready` is low. Verdicts leave in the order requests were accepted.
- R11: While `rst` is high at a rising edge, `out_valid` is cleared after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_vaddr | input | 32 | Virtual address |
| in_mode | input | 2 | Privilege mode (00 user, 01 supervisor, 1x kernel) |
| in_access | input | 2 | Access kind (00 load, 01 store, 10 fetch, 11 as load) |
| in_erl | input | 1 | Error-level flag |
| out_valid | output | 1 | Verdict present |
| out_ready | input | 1 | Consumer takes the verdict this cycle |
| out_unmapped | output | 1 | Direct verdict; `out_phys` is meaningful |
| out_to_tlb | output | 1 | Translate verdict |
| out_addr_err | output | 1 | Address error verdict |
| out_err_store | output | 1 | Address error is of store class |
| out_phys | output | 32 | Physical address for the direct verdict, else zero |

## Verification
Every verdict is due in the cycle after its request is accepted. It stays due until the edge where it is drained, so its timing depends only on the two handshakes and not on the address or the mode. The bench sets both channel controls on the falling edge and lets them settle. It then decides, from the values that the next rising edge will see, whether a request enters and whether a verdict leaves. It pushes the expected verdict of an entering request onto a queue and compares a leaving verdict against the head of that queue. It also checks that a stalled verdict is unchanged one cycle later.

// File: rtl/seg_pkg.sv
package seg_pkg;

  typedef enum logic [1:0] {
    PRIV_USER     = 2'b00,
    PRIV_SUPER    = 2'b01,
    PRIV_KERN     = 2'b10,
    PRIV_KERN_ALT = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_OTHER = 2'b11
  } access_e;

  // Address windows, selected by the top bits of the virtual address.
  typedef enum logic [2:0] {
    WIN_USER     = 3'd0,
    WIN_KDIRECT0 = 3'd1,
    WIN_KDIRECT1 = 3'd2,
    WIN_SUPMAP   = 3'd3,
    WIN_KMAP     = 3'd4
  } window_e;

  typedef enum logic [1:0] {
    VERDICT_DIRECT = 2'd0,
    VERDICT_TLB    = 2'd1,
    VERDICT_FAULT  = 2'd2
  } verdict_e;

  function automatic logic priv_is_kernel(priv_e p);
    return (p == PRIV_KERN) || (p == PRIV_KERN_ALT);
  endfunction

  function automatic logic priv_is_super(priv_e p);
    return p == PRIV_SUPER;
  endfunction

endpackage

// File: rtl/seg_classify.sv
module seg_classify
  import seg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] vaddr,
  output window_e           win
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    if (!vaddr[TOP]) begin
      win = WIN_USER;
    end else begin
      unique case (vaddr[TOP-1:TOP-2])
        2'b00:   win = WIN_KDIRECT0;
        2'b01:   win = WIN_KDIRECT1;
        2'b10:   win = WIN_SUPMAP;
        default: win = WIN_KMAP;
      endcase
    end
  end
endmodule

// File: rtl/seg_policy.sv
module seg_policy
  import seg_pkg::*;
(
  input  window_e  win,
  input  priv_e    priv,
  input  access_e  access,
  input  logic     erl,
  output verdict_e verdict,
  output logic     fault_store
);
  logic kern;
  logic sup;

  always_comb begin
    kern = priv_is_kernel(priv);
    sup  = priv_is_super(priv);
    unique case (win)
      WIN_USER:     verdict = erl ? VERDICT_DIRECT : VERDICT_TLB;
      WIN_KDIRECT0,
      WIN_KDIRECT1: verdict = kern ? VERDICT_DIRECT : VERDICT_FAULT;
      WIN_SUPMAP:   verdict = (kern || sup) ? VERDICT_TLB : VERDICT_FAULT;
      default:      verdict = kern ? VERDICT_TLB : VERDICT_FAULT;
    endcase
    fault_store = (verdict == VERDICT_FAULT) && (access == ACC_STORE);
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  window_e           win,
  output logic [ADDR_W-1:0] phys
);
  localparam int HI_W  = 3;
  localparam int LOW_W = ADDR_W - HI_W;

  logic [ADDR_W-1:0] direct_phys;

  // Both kernel direct windows are aligned to their own size, so removing
  // the base is the same as clearing the top bits.
  assign direct_phys = {{HI_W{1'b0}}, vaddr[LOW_W-1:0]};

  always_comb begin
    unique case (win)
      WIN_USER:     phys = vaddr;
      WIN_KDIRECT0,
      WIN_KDIRECT1: phys = direct_phys;
      default:      phys = '0;
    endcase
  end
endmodule

// File: rtl/addr_seg_decoder.sv
module addr_seg_decoder
  import seg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_vaddr,
  input  logic [1:0]        in_mode,
  input  logic [1:0]        in_access,
  input  logic              in_erl,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_unmapped,
  output logic              out_to_tlb,
  output logic              out_addr_err,
  output logic              out_err_store,
  output logic [ADDR_W-1:0] out_phys
);
  window_e           win;
  verdict_e          verdict;
  logic              fault_store;
  logic [ADDR_W-1:0] phys_raw;
  logic [ADDR_W-1:0] phys_gated;
  logic              take;

  seg_classify #(.ADDR_W(ADDR_W)) u_classify (
    .vaddr (in_vaddr),
    .win   (win)
  );

  seg_policy u_policy (
    .win         (win),
    .priv        (priv_e'(in_mode)),
    .access      (access_e'(in_access)),
    .erl         (in_erl),
    .verdict     (verdict),
    .fault_store (fault_store)
  );

  seg_xlate #(.ADDR_W(ADDR_W)) u_xlate (
    .vaddr (in_vaddr),
    .win   (win),
    .phys  (phys_raw)
  );

  assign phys_gated = (verdict == VERDICT_DIRECT) ? phys_raw : '0;
  assign in_ready   = !out_valid || out_ready;
  assign take       = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_unmapped  <= 1'b0;
      out_to_tlb    <= 1'b0;
      out_addr_err  <= 1'b0;
      out_err_store <= 1'b0;
      out_phys      <= '0;
    end else begin
      if (in_ready) begin
        out_valid <= in_valid;
      end
      if (take) begin
        out_unmapped  <= (verdict == VERDICT_DIRECT);
        out_to_tlb    <= (verdict == VERDICT_TLB);
        out_addr_err  <= (verdict == VERDICT_FAULT);
        out_err_store <= fault_store;
        out_phys      <= phys_gated;
      end
    end
  end
endmodule

// File: rtl/addr_seg_decoder_chk.sv
module addr_seg_decoder_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_vaddr,
  input logic [1:0]        in_mode,
  input logic              in_erl,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_unmapped,
  input logic              out_to_tlb,
  input logic              out_addr_err,
  input logic              out_err_store,
  input logic [ADDR_W-1:0] out_phys
);
  localparam int TOP = ADDR_W - 1;

  logic acc;
  assign acc = in_valid && in_ready;

  assert_user_tlb_R1: assert property (@(posedge clk) disable iff (rst)
    acc && !in_vaddr[TOP] && !in_erl |=> out_to_tlb);

  assert_erl_identity_R2: assert property (@(posedge clk) disable iff (rst)
    acc && !in_vaddr[TOP] && in_erl |=> out_unmapped && (out_phys == $past(in_vaddr)));

  assert_store_gate_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_addr_err |-> !out_err_store);

  assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot({out_unmapped, out_to_tlb, out_addr_err}));

  assert_phys_zero_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_unmapped |-> out_phys == '0);

  assert_kernel_no_fault_R9: assert property (@(posedge clk) disable iff (rst)
    acc && in_mode[1] |=> !out_addr_err);

  assert_ready_R10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_phys) && $stable(out_unmapped)
      && $stable(out_to_tlb) && $stable(out_addr_err) && $stable(out_err_store));
endmodule

bind addr_seg_decoder addr_seg_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_vaddr      (in_vaddr),
  .in_mode       (in_mode),
  .in_erl        (in_erl),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_unmapped  (out_unmapped),
  .out_to_tlb    (out_to_tlb),
  .out_addr_err  (out_addr_err),
  .out_err_store (out_err_store),
  .out_phys      (out_phys)
);

// File: tb/sim_addr_seg_decoder.sv
`timescale 1ns/1ps
module sim_addr_seg_decoder;

  typedef struct {
    logic        u;
    logic        t;
    logic        e;
    logic        st;
    logic [31:0] ph;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_vaddr = '0;
  logic [1:0]  in_mode = '0;
  logic [1:0]  in_access = '0;
  logic        in_erl = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_unmapped;
  logic        out_to_tlb;
  logic        out_addr_err;
  logic        out_err_store;
  logic [31:0] out_phys;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  exp_t q[$];
  bit          stalled = 1'b0;
  logic [35:0] held;

  localparam int N_DIRECTED = 240;
  localparam int N_RANDOM   = 3000;

  always #2.5 clk = ~clk;

  addr_seg_decoder u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_vaddr(in_vaddr), .in_mode(in_mode), .in_access(in_access), .in_erl(in_erl),
    .out_valid(out_valid), .out_ready(out_ready), .out_unmapped(out_unmapped),
    .out_to_tlb(out_to_tlb), .out_addr_err(out_addr_err),
    .out_err_store(out_err_store), .out_phys(out_phys)
  );

  function automatic exp_t model(logic [31:0] va, logic [1:0] md, logic [1:0] ac, logic erl);
    exp_t r;
    bit kern = (md == 2'b10) || (md == 2'b11); // R9
    bit sup  = (md == 2'b01);
    r.u = 0; r.t = 0; r.e = 0; r.st = 0; r.ph = '0;
    if (va < 32'h8000_0000) begin
      if (erl) begin r.u = 1; r.ph = va; r.tag = "R2"; end
      else     begin r.t = 1; r.tag = "R1"; end
    end else if (va < 32'hA000_0000) begin
      r.tag = "R3";
      if (kern) begin r.u = 1; r.ph = va - 32'h8000_0000; end else r.e = 1;
    end else if (va < 32'hC000_0000) begin
      r.tag = "R4";
      if (kern) begin r.u = 1; r.ph = va - 32'hA000_0000; end else r.e = 1;
    end else if (va < 32'hE000_0000) begin
      r.tag = "R5";
      if (kern || sup) r.t = 1; else r.e = 1;
    end else begin
      r.tag = "R6";
      if (kern) r.t = 1; else r.e = 1;
    end
    if (md == 2'b11 || (erl && va >= 32'h8000_0000)) r.tag = "R9";
    if (r.e) begin
      r.st = (ac == 2'b01);
      if (ac != 2'b00) r.tag = "R7";
    end
    return r;
  endfunction

  function automatic logic [31:0] corner(int k);
    case (k)
      0: return 32'h0000_0000;  1: return 32'h7FFF_FFFF;
      2: return 32'h8000_0000;  3: return 32'h9FFF_FFFF;
      4: return 32'hA000_0000;  5: return 32'hBFFF_FFFF;
      6: return 32'hC000_0000;  7: return 32'hDFFF_FFFF;
      8: return 32'hE000_0000;  default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic pick(int idx);
    if (idx < N_DIRECTED) begin
      in_vaddr  = corner(idx % 10);
      in_mode   = 2'((idx / 10) % 4);
      in_access = (((idx / 40) % 3) == 0) ? 2'b00 : ((((idx / 40) % 3) == 1) ? 2'b01 : 2'b10);
      in_erl    = ((idx / 120) % 2) == 1;
    end else begin
      in_vaddr  = {3'($urandom_range(0, 7)), 29'($urandom)};
      in_mode   = 2'($urandom_range(0, 3));
      in_access = 2'($urandom_range(0, 3));
      in_erl    = ($urandom_range(0, 3) == 0);
    end
  endtask

  task automatic check1(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic evaluate();
    bit fin = in_valid && in_ready;
    bit fout = out_valid && out_ready;
    logic [35:0] cur = {out_unmapped, out_to_tlb, out_addr_err, out_err_store, out_phys};
    if (stalled) begin
      check1(out_valid == 1'b1, "R10", "valid dropped during stall", 64'(out_valid), 64'd1);
      check1(cur == held, "R10", "outputs moved during stall", 64'(cur), 64'(held));
    end
    check1(in_ready == (!out_valid || out_ready), "R10", "in_ready",
           64'(in_ready), 64'(!out_valid || out_ready));
    if (fout) begin
      if (q.size() == 0) begin
        check1(1'b0, "R10", "verdict with nothing accepted", 64'(cur), 64'd0);
      end else begin
        exp_t x = q.pop_front();
        logic [35:0] ev = {x.u, x.t, x.e, x.st, x.ph};
        check1(cur == ev, x.tag, "verdict {unm,tlb,err,st,phys}", 64'(cur), 64'(ev));
      end
    end
    if (fin) q.push_back(model(in_vaddr, in_mode, in_access, in_erl));
    stalled = out_valid && !out_ready;
    held = cur;
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin : main
    int sent = 0;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check1(out_valid == 1'b0, "R11", "out_valid in reset", 64'(out_valid), 64'd0);
    check1(in_ready == 1'b1, "R11", "in_ready in reset", 64'(in_ready), 64'd1);
    rst = 1'b0;
    while (sent < N_DIRECTED + N_RANDOM) begin
      @(negedge clk);
      pick(sent);
      in_valid  = ($urandom_range(0, 3) != 0);
      out_ready = ($urandom_range(0, 3) != 0);
      #1;
      evaluate();
      if (in_valid && in_ready) sent++;
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    for (int k = 0; k < 8; k++) begin
      #1;
      evaluate();
      @(negedge clk);
    end
    check1(q.size() == 0, "R10", "verdicts left undelivered", 64'(q.size()), 64'd0);
    check1(out_valid == 1'b0, "R10", "out_valid after drain", 64'(out_valid), 64'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule